// File: doc/BRIEF.md
# Duty-Cycled Magnetic Pole Switch

This block turns a stream of signed flux-density samples into a single switch output while keeping the sampling front end idle for most of the time. A timer, driven by a slow clock enable, splits every operating cycle into a short awake window and a much longer sleep window. The block requests a sample only while awake. It takes the first valid sample of the window, and when the window closes it updates a hysteretic detect state from that sample.

The flux input is a two's-complement value in tenths of a millitesla. Positive values stand for the S pole and negative values for the N pole. The detector can watch either pole, only S, or only N. It offers three operate/release threshold pairs. The switch output can be active-low or active-high. It can drive push-pull, or emulate an open-drain pin by holding the data at 0 and using an output-enable. The cycle timing is set by parameters. For example, with a 50 µs tick, 2 awake ticks and 1008 sleep ticks give a 50.50 ms cycle.

Top module: `pole_switch_sampler`

## Requirements
- R1: After reset the block starts an awake window. It spends AWAKE_TICKS ticks awake and then SLEEP_TICKS ticks asleep, and this repeats. `smp_req` is high only while awake, from the start of the window until a sample is taken.
- R2: Within one awake window only the first cycle with `smp_req` and `smp_valid` both high captures `smp_flux`. Later valid samples in the same window are ignored.
- R3: The detect state changes only in the cycle after the last tick of an awake window. It stays frozen during the rest of the awake window and through sleep.
- R4: If no sample was captured in a window, the detect state is kept when that window closes.
- R5: A captured magnitude greater than or equal to the operate threshold sets the state to detected.
- R6: A magnitude below the release threshold sets the state to released. A magnitude from the release threshold up to one below the operate threshold keeps the previous state.
- R7: `cfg_pole` selects what the magnitude is. With 0 or 3 (both poles) it is the absolute flux. With 1 (S only) it is the flux when positive and 0 otherwise. With 2 (N only) it is the negated flux when negative and 0 otherwise.
- R8: `cfg_sens` selects the operate/release pair in 0.1 mT units: 0 gives 18/11, 1 gives 30/22, and 2 or 3 give 45/35.
- R9: With `cfg_act_high`=1 the active level is 1 when detected and 0 when released. With `cfg_act_high`=0 the levels are inverted.
- R10: With `cfg_open_drain`=0 the outputs are `sw_oe`=1 and `sw_out`=level. With `cfg_open_drain`=1 they are `sw_out`=0 and `sw_oe`=1 only when the level is 0.
- R11: After reset the state is released, so the output shows the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow timing enable, one cycle wide |
| smp_req | output | 1 | Sample request, high while awake until a sample is taken |
| smp_valid | input | 1 | Sample valid |
| smp_flux | input | FLUX_W | Signed flux in 0.1 mT, positive is S |
| cfg_pole | input | 2 | Pole mode: 0/3 both, 1 S only, 2 N only |
| cfg_sens | input | 2 | Threshold pair select |
| cfg_act_high | input | 1 | 1: detected drives level 1 |
| cfg_open_drain | input | 1 | 1: open-drain emulation |
| sw_out | output | 1 | Switch data |
| sw_oe | output | 1 | Switch output enable |

## Verification
The assertions assume that `tick` is a single-cycle pulse. They also assume that the configuration inputs stay steady from the sample to the close of the window, because the decision reads them at the close. The stimulus meets both assumptions. The tick comes from a fixed divide-by-four counter. Configuration and samples change only at the start of an awake window, once the request is seen, so every sample lands well before the window closes. Flux values stay within ±6.0 mT, which covers every threshold pair and lies far inside the input range.

// File: rtl/pole_switch_sampler.sv
module pole_switch_sampler #(
  parameter int FLUX_W      = 12,
  parameter int AWAKE_TICKS = 2,
  parameter int SLEEP_TICKS = 1008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic              smp_req,
  input  logic              smp_valid,
  input  logic [FLUX_W-1:0] smp_flux,
  input  logic [1:0]        cfg_pole,
  input  logic [1:0]        cfg_sens,
  input  logic              cfg_act_high,
  input  logic              cfg_open_drain,
  output logic              sw_out,
  output logic              sw_oe
);
  localparam int CNT_MAX = (AWAKE_TICKS > SLEEP_TICKS) ? AWAKE_TICKS : SLEEP_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int MW      = FLUX_W + 1;

  logic             awake, got, det;
  logic [CNT_W-1:0] cnt;
  logic [FLUX_W-1:0] smp_q;

  logic signed [MW-1:0] fx, s_mag, n_mag, mag, op_t, rp_t;
  logic win_end, sleep_end, det_nxt, level;

  assign smp_req   = awake && !got;
  assign win_end   = tick && awake && (cnt == CNT_W'(AWAKE_TICKS - 1));
  assign sleep_end = tick && !awake && (cnt == CNT_W'(SLEEP_TICKS - 1));

  assign fx    = {smp_q[FLUX_W-1], smp_q};
  assign s_mag = (fx > 0) ? fx : '0;
  assign n_mag = (fx < 0) ? -fx : '0;

  always_comb begin
    case (cfg_pole)
      2'd1:    mag = s_mag;
      2'd2:    mag = n_mag;
      default: mag = s_mag | n_mag;
    endcase
    case (cfg_sens)
      2'd0:    begin op_t = MW'(18); rp_t = MW'(11); end
      2'd1:    begin op_t = MW'(30); rp_t = MW'(22); end
      default: begin op_t = MW'(45); rp_t = MW'(35); end
    endcase
    if (mag >= op_t)     det_nxt = 1'b1;
    else if (mag < rp_t) det_nxt = 1'b0;
    else                 det_nxt = det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake <= 1'b1;
      cnt   <= '0;
      got   <= 1'b0;
      det   <= 1'b0;
      smp_q <= '0;
    end else begin
      if (smp_req && smp_valid) begin
        got   <= 1'b1;
        smp_q <= smp_flux;
      end
      if (win_end) begin
        awake <= 1'b0;
        cnt   <= '0;
        got   <= 1'b0;
        if (got) det <= det_nxt;
      end else if (sleep_end) begin
        awake <= 1'b1;
        cnt   <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign level  = det ? cfg_act_high : !cfg_act_high;
  assign sw_out = cfg_open_drain ? 1'b0 : level;
  assign sw_oe  = cfg_open_drain ? !level : 1'b1;
endmodule

// File: rtl/pole_switch_sampler_chk.sv
module pole_switch_sampler_chk #(
  parameter int CNT_W       = 2,
  parameter int AWAKE_TICKS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             awake,
  input logic             got,
  input logic             det,
  input logic [CNT_W-1:0] cnt,
  input logic             smp_req,
  input logic             smp_valid
);
  assert_req_only_awake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> awake);

  assert_awake_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    awake |-> (cnt < CNT_W'(AWAKE_TICKS)));

  assert_one_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && smp_valid) |=> !smp_req);

  assert_frozen_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> $stable(det));

  assert_hold_no_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !got) |=> $stable(det));
endmodule

bind pole_switch_sampler pole_switch_sampler_chk #(.CNT_W(CNT_W), .AWAKE_TICKS(AWAKE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .awake(awake), .got(got), .det(det),
  .cnt(cnt), .smp_req(smp_req), .smp_valid(smp_valid)
);

// File: tb/tb_pole_switch_sampler.sv
module tb_pole_switch_sampler;
  localparam int FW = 12, AW = 2, SL = 5, TDIV = 4;

  logic clk = 0, rst_n = 0, tick = 0, smp_valid = 0;
  logic [FW-1:0] smp_flux = '0;
  logic [1:0] cfg_pole = 0, cfg_sens = 0;
  logic cfg_act_high = 0, cfg_open_drain = 0;
  logic smp_req, sw_out, sw_oe;
  int n_chk = 0, n_fail = 0, tdiv = 0;
  bit exp_det = 0;
  bit first_win = 1;
  string prev_tag = "R11";

  pole_switch_sampler #(.FLUX_W(FW), .AWAKE_TICKS(AW), .SLEEP_TICKS(SL)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .smp_req(smp_req), .smp_valid(smp_valid),
    .smp_flux(smp_flux), .cfg_pole(cfg_pole), .cfg_sens(cfg_sens),
    .cfg_act_high(cfg_act_high), .cfg_open_drain(cfg_open_drain),
    .sw_out(sw_out), .sw_oe(sw_oe));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TDIV - 1);
  end

  function automatic bit next_det(bit d, int f, int pole, int sens);
    int m, op, rp;
    case (pole)
      1: m = (f > 0) ? f : 0;
      2: m = (f < 0) ? -f : 0;
      default: m = (f < 0) ? -f : f;
    endcase
    case (sens)
      0: begin op = 18; rp = 11; end
      1: begin op = 30; rp = 22; end
      default: begin op = 45; rp = 35; end
    endcase
    if (m >= op) return 1'b1;
    if (m < rp) return 1'b0;
    return d;
  endfunction

  function automatic logic [1:0] exp_pins(bit d, bit ah, bit od);
    bit lv;
    lv = d ? ah : !ah;
    return od ? {1'b0, !lv} : {lv, 1'b1};
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out/oe got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_pins(string tag);
    check(tag, {sw_out, sw_oe}, exp_pins(exp_det, cfg_act_high, cfg_open_drain));
  endtask

  task automatic pulse(int f);
    smp_flux  = FW'(f);
    smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  // entry: at a negedge with smp_req high (window start)
  task automatic window(string tag, int pole, int sens, bit ah, bit od,
                        bit do_smp, int f, bit second, int f2);
    int cyc;
    check_pins(prev_tag);
    cfg_pole = 2'(pole); cfg_sens = 2'(sens); cfg_act_high = ah; cfg_open_drain = od;
    #1 check_pins("R9 R10 config");
    if (do_smp) begin
      @(negedge clk);
      pulse(f);
      if (second) pulse(f2);
      check_pins("R3 unchanged before close");
      exp_det = next_det(exp_det, f, pole, sens);
    end
    cyc = 0;
    while (smp_req) begin @(negedge clk); cyc++; end
    while (!smp_req) begin @(negedge clk); cyc++; end
    prev_tag = tag;
    if (!first_win) begin
      n_chk++;
      if (cyc < (AW + SL) * TDIV - 1 - 2*TDIV || cyc > (AW + SL) * TDIV + 1) begin
        n_fail++;
        $display("FAIL R1: window period %0d expected about %0d", cyc, (AW + SL) * TDIV);
      end
    end
    first_win = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5712));
    repeat (3) @(negedge clk);
    #1 check_pins("R11 in reset");
    rst_n = 1;
    @(negedge clk);
    check_pins("R11 after reset");
    while (!smp_req) @(negedge clk);
    // directed corners (both poles, 3.0/2.2 set, active low, push-pull)
    window("R5 below operate", 0, 1, 0, 0, 1, 29, 0, 0);
    window("R5 at operate",    0, 1, 0, 0, 1, 30, 0, 0);
    window("R6 at release holds", 0, 1, 0, 0, 1, 22, 0, 0);
    window("R7 both N in band holds", 0, 1, 0, 0, 1, -25, 0, 0);
    window("R4 no sample",     0, 1, 0, 0, 0, 0, 0, 0);
    window("R6 below release", 0, 1, 0, 0, 1, 21, 0, 0);
    window("R7 both N detect", 0, 1, 0, 0, 1, -30, 0, 0);
    window("R7 S only ignores N", 1, 1, 0, 0, 1, -50, 0, 0);
    window("R7 S only detect", 1, 1, 0, 0, 1, 50, 0, 0);
    window("R7 N only ignores S", 2, 1, 0, 0, 1, 50, 0, 0);
    window("R7 N only detect", 2, 1, 0, 0, 1, -45, 0, 0);
    window("R8 set0 at release holds", 2, 0, 0, 0, 1, -11, 0, 0);
    window("R8 set0 release", 2, 0, 0, 0, 1, -10, 0, 0);
    window("R8 set2 below operate", 2, 2, 0, 0, 1, -44, 0, 0);
    window("R8 set2 operate", 3, 2, 0, 0, 1, -45, 0, 0);
    window("R2 second sample ignored", 0, 2, 1, 1, 1, 0, 1, 60);
    window("R9 R10 active high open drain", 0, 0, 1, 1, 1, 18, 0, 0);
    window("R4 no sample open drain", 0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 150; i++) begin
      int f;
      f = int'($urandom % 121) - 60;
      window("R5 R6 R7 R8 random", int'($urandom % 4), int'($urandom % 4),
             1'($urandom % 2), 1'($urandom % 2), ($urandom % 8) != 0, f,
             ($urandom % 4) == 0, int'($urandom % 121) - 60);
    end
    check_pins(prev_tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule